// File: doc/BRIEF.md
# Interrupt Controller Base and Mode Register

This block holds the 64-bit control register that tells a core where its local interrupt controller sits in physical memory and in which mode it runs. The register carries a page-aligned physical base address, a boot-core flag, a global enable and an extended-mode enable. Every write is checked against the reserved-bit rules and a legal mode-transition table. An illegal write changes nothing and raises a one-cycle fault pulse that the core turns into an exception.

The block also decodes a 4 KiB memory-mapped register window at the programmed base. The window serves three registers: a read-only version word, a task-priority view of a 4-bit priority input, and a local ID. The current mode shapes the window. When the controller is disabled, reads return all ones and writes are dropped. In plain enabled mode the ID is writable. In extended mode the ID is read-only and reads back in the low byte. Reprogramming the base moves the whole window.

Top module: `intc_base_top`

## Requirements
- R1: After reset the control register reads 0x0000_0000_FEE0_0900: base 0xFEE00000, boot flag (bit 8) set, enable (bit 11) set, extended (bit 10) clear. presentOut is 1 and cfgFault is 0.
- R2: A legal write shows on cfgRdData from the cycle after the write, and cfgFault stays 0.
- R3: A write that sets any of bits 7:0, bit 9, or any bit at or above PHYS_ADDR_W is illegal. The register keeps its old value and cfgFault is 1 for exactly the one cycle after that write.
- R4: The mode is {bit 11, bit 10}: 00 disabled, 10 enabled, 11 extended. A write that asks for 01 (extended without enable) faults from any state.
- R5: Going straight from extended to enabled faults. Going from extended to disabled is legal.
- R6: Going straight from disabled to extended faults. Going from enabled to extended is legal.
- R7: With EXT_SUPPORTED = 0, any write that sets bit 10 faults.
- R8: The window answers only when memAddr[PHYS_ADDR_W-1:12] equals the programmed base. After a move, the version word (offset 0x30) reads the same value at the new base, and reads at the old base return 0.
- R9: While disabled, presentOut is 0, any window read returns 0xFFFFFFFF, and window writes change nothing and raise no fault.
- R10: A window read returns memRdValid and memRdData in the cycle after memValid. memRdValid is 0 when there was no read the cycle before.
- R11: Offset 0x80 reads {24'b0, taskPri, 4'b0}.
- R12: In enabled mode, a write to offset 0x20 loads the ID from memWrData[31:24], and a read of 0x20 returns {id, 24'b0}. Unmapped offsets read 0.
- R13: In extended mode, a read of 0x20 returns {24'b0, id}. A write to 0x20 leaves the ID unchanged and sets winFault to 1 for the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 64 | Control register write value |
| cfgRdData | output | 64 | Current control register contents |
| cfgFault | output | 1 | One-cycle pulse after an illegal control write |
| memValid | input | 1 | Window access request |
| memWrite | input | 1 | 1 = write access, 0 = read |
| memAddr | input | PHYS_ADDR_W | Physical address of the access |
| memWrData | input | 32 | Window write data |
| memRdValid | output | 1 | Read response strobe |
| memRdData | output | 32 | Read response data |
| winFault | output | 1 | One-cycle pulse after an ID write in extended mode |
| taskPri | input | 4 | Current task priority |
| presentOut | output | 1 | Controller present (enable bit) |
| extActive | output | 1 | Extended mode active |

## Verification
Control writes and window accesses are registered, so their results appear one clock edge after the request. This covers the new register value, both fault pulses, the read response and the ID update. The bench drives each request on a falling edge and releases it on the next falling edge. It checks the response at that second falling edge, which falls after exactly one rising edge. For fault pulses and the read strobe, it checks one more falling edge later that the pulse has dropped.

// File: rtl/intc_base_pkg.sv
package intc_base_pkg;

  // {enable, extended}
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_BAD = 2'b01,
    MODE_ON  = 2'b10,
    MODE_EXT = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_ONES,
    SEL_ID,
    SEL_VER,
    SEL_TPR
  } rdsel_e;

  typedef struct packed {
    logic   cfgLoad;
    logic   idLoad;
    logic   rdFire;
    rdsel_e rdSel;
  } strobe_t;

  localparam int          PAGE_BITS = 12;
  localparam int          BOOT_BIT  = 8;
  localparam int          EXT_BIT   = 10;
  localparam int          EN_BIT    = 11;
  localparam logic [11:0] OFS_ID    = 12'h020;
  localparam logic [11:0] OFS_VER   = 12'h030;
  localparam logic [11:0] OFS_TPR   = 12'h080;

endpackage

// File: rtl/intc_base_ctrl.sv
module intc_base_ctrl
  import intc_base_pkg::*;
#(
  parameter int PHYS_ADDR_W   = 36,
  parameter bit EXT_SUPPORTED = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [63:0] cfgWrData,
  input  mode_e       curMode,
  input  logic        memValid,
  input  logic        memWrite,
  input  logic [11:0] memOffset,
  input  logic        baseHit,
  output strobe_t     stb,
  output logic        cfgFault,
  output logic        winFault
);

  localparam logic [63:0] ADDR_FIELD = ((64'd1 << PHYS_ADDR_W) - 64'd1) & ~((64'd1 << PAGE_BITS) - 64'd1);
  localparam logic [63:0] FLAG_FIELD = (64'd1 << BOOT_BIT) | (64'd1 << EXT_BIT) | (64'd1 << EN_BIT);
  localparam logic [63:0] RSVD_MASK  = ~(ADDR_FIELD | FLAG_FIELD);

  mode_e reqMode;
  logic  transOk;
  logic  extBlocked;
  logic  badWrite;
  logic  winLive;
  logic  idWrite;

  assign reqMode    = mode_e'({cfgWrData[EN_BIT], cfgWrData[EXT_BIT]});
  assign extBlocked = !EXT_SUPPORTED && cfgWrData[EXT_BIT];

  always_comb begin
    unique case (curMode)
      MODE_OFF: transOk = (reqMode == MODE_OFF) || (reqMode == MODE_ON);
      MODE_ON:  transOk = (reqMode != MODE_BAD);
      MODE_EXT: transOk = (reqMode == MODE_OFF) || (reqMode == MODE_EXT);
      default:  transOk = 1'b0;
    endcase
  end

  assign badWrite = (|(cfgWrData & RSVD_MASK)) || !transOk || extBlocked;

  assign winLive = (curMode == MODE_ON) || (curMode == MODE_EXT);
  assign idWrite = memValid && memWrite && baseHit && (memOffset == OFS_ID);

  always_comb begin
    stb.cfgLoad = cfgWrEn && !badWrite;
    stb.idLoad  = idWrite && (curMode == MODE_ON);
    stb.rdFire  = memValid && !memWrite;
    if (!baseHit)
      stb.rdSel = SEL_ZERO;
    else if (!winLive)
      stb.rdSel = SEL_ONES;
    else begin
      unique case (memOffset)
        OFS_ID:  stb.rdSel = SEL_ID;
        OFS_VER: stb.rdSel = SEL_VER;
        OFS_TPR: stb.rdSel = SEL_TPR;
        default: stb.rdSel = SEL_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgFault <= 1'b0;
      winFault <= 1'b0;
    end else begin
      cfgFault <= cfgWrEn && badWrite;
      winFault <= idWrite && (curMode == MODE_EXT);
    end
  end

endmodule

// File: rtl/intc_base_dp.sv
module intc_base_dp
  import intc_base_pkg::*;
#(
  parameter int          PHYS_ADDR_W = 36,
  parameter logic [63:0] RESET_BASE  = 64'hFEE0_0000,
  parameter bit          BOOT_CORE   = 1'b1,
  parameter logic [31:0] VERSION     = 32'h0005_0014,
  parameter int          ID_W        = 8,
  parameter logic [ID_W-1:0] INIT_ID = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [63:0]            cfgWrData,
  input  logic [PHYS_ADDR_W-1:0] memAddr,
  input  logic [ID_W-1:0]        idWrVal,
  input  logic [3:0]             taskPri,
  output mode_e                  curMode,
  output logic                   baseHit,
  output logic [63:0]            cfgRdData,
  output logic                   memRdValid,
  output logic [31:0]            memRdData
);

  localparam logic [63:0] RESET_VAL = RESET_BASE | (64'd1 << EN_BIT) | (64'(BOOT_CORE) << BOOT_BIT);
  localparam int          ID_PAD    = 32 - ID_W;

  logic [63:0]     cfgReg;
  logic [ID_W-1:0] idReg;
  logic [31:0]     rdNext;

  assign curMode   = mode_e'({cfgReg[EN_BIT], cfgReg[EXT_BIT]});
  assign baseHit   = memAddr[PHYS_ADDR_W-1:PAGE_BITS] == cfgReg[PHYS_ADDR_W-1:PAGE_BITS];
  assign cfgRdData = cfgReg;

  always_comb begin
    unique case (stb.rdSel)
      SEL_ONES: rdNext = '1;
      SEL_ID:   rdNext = (curMode == MODE_EXT) ? {{ID_PAD{1'b0}}, idReg} : {idReg, {ID_PAD{1'b0}}};
      SEL_VER:  rdNext = VERSION;
      SEL_TPR:  rdNext = {24'b0, taskPri, 4'b0};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg     <= RESET_VAL;
      idReg      <= INIT_ID;
      memRdValid <= 1'b0;
      memRdData  <= '0;
    end else begin
      if (stb.cfgLoad) cfgReg <= cfgWrData;
      if (stb.idLoad)  idReg  <= idWrVal;
      memRdValid <= stb.rdFire;
      if (stb.rdFire) memRdData <= rdNext;
    end
  end

endmodule

// File: rtl/intc_base_top.sv
module intc_base_top
  import intc_base_pkg::*;
#(
  parameter int          PHYS_ADDR_W   = 36,
  parameter bit          EXT_SUPPORTED = 1'b1,
  parameter logic [63:0] RESET_BASE    = 64'hFEE0_0000,
  parameter bit          BOOT_CORE     = 1'b1,
  parameter logic [31:0] VERSION       = 32'h0005_0014,
  parameter logic [7:0]  INIT_ID       = 8'h00
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [63:0]            cfgWrData,
  output logic [63:0]            cfgRdData,
  output logic                   cfgFault,
  input  logic                   memValid,
  input  logic                   memWrite,
  input  logic [PHYS_ADDR_W-1:0] memAddr,
  input  logic [31:0]            memWrData,
  output logic                   memRdValid,
  output logic [31:0]            memRdData,
  output logic                   winFault,
  input  logic [3:0]             taskPri,
  output logic                   presentOut,
  output logic                   extActive
);

  localparam int ID_W = 8;

  strobe_t stb;
  mode_e   curMode;
  logic    baseHit;

  intc_base_ctrl #(
    .PHYS_ADDR_W  (PHYS_ADDR_W),
    .EXT_SUPPORTED(EXT_SUPPORTED)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .curMode  (curMode),
    .memValid (memValid),
    .memWrite (memWrite),
    .memOffset(memAddr[11:0]),
    .baseHit  (baseHit),
    .stb      (stb),
    .cfgFault (cfgFault),
    .winFault (winFault)
  );

  intc_base_dp #(
    .PHYS_ADDR_W(PHYS_ADDR_W),
    .RESET_BASE (RESET_BASE),
    .BOOT_CORE  (BOOT_CORE),
    .VERSION    (VERSION),
    .ID_W       (ID_W),
    .INIT_ID    (INIT_ID)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgWrData (cfgWrData),
    .memAddr   (memAddr),
    .idWrVal   (memWrData[31:32-ID_W]),
    .taskPri   (taskPri),
    .curMode   (curMode),
    .baseHit   (baseHit),
    .cfgRdData (cfgRdData),
    .memRdValid(memRdValid),
    .memRdData (memRdData)
  );

  assign presentOut = cfgRdData[EN_BIT];
  assign extActive  = cfgRdData[EXT_BIT];

endmodule

// File: rtl/intc_base_chk.sv
module intc_base_chk #(
  parameter int PHYS_ADDR_W = 36
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cfgWrEn,
  input logic [63:0]            cfgRdData,
  input logic                   cfgFault,
  input logic                   memValid,
  input logic                   memWrite,
  input logic [PHYS_ADDR_W-1:0] memAddr,
  input logic                   memRdValid,
  input logic [31:0]            memRdData,
  input logic                   winFault
);

  // R3
  fault_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgFault |-> (cfgRdData == $past(cfgRdData) && $past(cfgWrEn)));

  // R4
  no_bad_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[11:10] != 2'b01);

  // R5
  ext_to_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgRdData[11:10]) == 2'b11) |-> (cfgRdData[11:10] != 2'b10));

  // R6
  off_to_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgRdData[11:10]) == 2'b00) |-> (cfgRdData[11:10] != 2'b11));

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid == $past(memValid && !memWrite));

  // R9
  ones_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && cfgRdData[11:10] == 2'b00 &&
     memAddr[PHYS_ADDR_W-1:12] == cfgRdData[PHYS_ADDR_W-1:12]) |=> (memRdData == 32'hFFFF_FFFF));

  // R13
  id_fault_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    winFault |-> ($past(cfgRdData[11:10]) == 2'b11 && $past(memValid && memWrite)));

endmodule

bind intc_base_top intc_base_chk #(.PHYS_ADDR_W(PHYS_ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgRdData (cfgRdData),
  .cfgFault  (cfgFault),
  .memValid  (memValid),
  .memWrite  (memWrite),
  .memAddr   (memAddr),
  .memRdValid(memRdValid),
  .memRdData (memRdData),
  .winFault  (winFault)
);

// File: tb/intc_base_top_tb_top.sv
module intc_base_top_tb_top;

  localparam int          PAW      = 36;
  localparam logic [31:0] VER      = 32'h0005_0014;
  localparam logic [63:0] RST_VAL  = 64'h0000_0000_FEE0_0900;
  localparam logic [63:0] V_ON     = 64'hFEE0_0900;
  localparam logic [63:0] V_EXT    = 64'hFEE0_0D00;
  localparam logic [63:0] V_OFF    = 64'hFEE0_0100;
  localparam logic [63:0] V_BADMD  = 64'hFEE0_0500;
  localparam logic [PAW-1:0] BASE  = 36'h0_FEE0_0000;
  localparam logic [PAW-1:0] ALT   = 36'h0_4200_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic           cfgWrEn = 1'b0;
  logic [63:0]    cfgWrData = '0;
  logic [63:0]    cfgRdData;
  logic           cfgFault;
  logic           memValid = 1'b0;
  logic           memWrite = 1'b0;
  logic [PAW-1:0] memAddr = '0;
  logic [31:0]    memWrData = '0;
  logic           memRdValid;
  logic [31:0]    memRdData;
  logic           winFault;
  logic [3:0]     taskPri = 4'h0;
  logic           presentOut;
  logic           extActive;

  logic           nxWrEn = 1'b0;
  logic [63:0]    nxWrData = '0;
  logic [63:0]    nxRdData;
  logic           nxFault;
  logic           nxRdValid;
  logic [31:0]    nxRdData32;
  logic           nxWinFault;
  logic           nxPresent;
  logic           nxExt;

  intc_base_top #(.PHYS_ADDR_W(PAW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .cfgFault(cfgFault), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memWrData(memWrData),
    .memRdValid(memRdValid), .memRdData(memRdData), .winFault(winFault),
    .taskPri(taskPri), .presentOut(presentOut), .extActive(extActive)
  );

  intc_base_top #(.PHYS_ADDR_W(PAW), .EXT_SUPPORTED(1'b0)) dutNoExt_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(nxWrEn), .cfgWrData(nxWrData),
    .cfgRdData(nxRdData), .cfgFault(nxFault), .memValid(1'b0),
    .memWrite(1'b0), .memAddr(BASE), .memWrData(32'h0),
    .memRdValid(nxRdValid), .memRdData(nxRdData32), .winFault(nxWinFault),
    .taskPri(4'h0), .presentOut(nxPresent), .extActive(nxExt)
  );

  int vecCnt  = 0;
  int failCnt = 0;
  bit done    = 1'b0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [63:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic win_rd(input logic [PAW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    memValid = 1'b1; memWrite = 1'b0; memAddr = a;
    @(negedge clk);
    memValid = 1'b0;
    check("R10", "read strobe", 64'(memRdValid), 64'd1);
    d = memRdData;
  endtask

  task automatic win_wr(input logic [PAW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    memValid = 1'b1; memWrite = 1'b1; memAddr = a; memWrData = d;
    @(negedge clk);
    memValid = 1'b0; memWrite = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "reset value", cfgRdData, RST_VAL);
    check("R1", "present", 64'(presentOut), 64'd1);
    check("R1", "no fault", 64'(cfgFault), 64'd0);
    check("R1", "ext clear", 64'(extActive), 64'd0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    win_rd(BASE | 36'h030, d);  check("R12", "version", 64'(d), 64'(VER));
    @(negedge clk);
    check("R10", "strobe drops", 64'(memRdValid), 64'd0);
    win_rd(BASE | 36'h020, d);  check("R12", "initial id", 64'(d), 64'h0);
    win_wr(BASE | 36'h020, 32'h5A00_0000);
    check("R12", "no win fault", 64'(winFault), 64'd0);
    win_rd(BASE | 36'h020, d);  check("R12", "id written", 64'(d), 64'h5A00_0000);
    win_rd(BASE | 36'h040, d);  check("R12", "unmapped", 64'(d), 64'h0);
    taskPri = 4'hB;
    win_rd(BASE | 36'h080, d);  check("R11", "tpr B", 64'(d), 64'h0000_00B0);
    taskPri = 4'h3;
    win_rd(BASE | 36'h080, d);  check("R11", "tpr 3", 64'(d), 64'h0000_0030);
  endtask

  task automatic t_reserved();
    cfg_wr(V_ON | 64'h1);
    check("R3", "bit0 fault", 64'(cfgFault), 64'd1);
    check("R3", "bit0 unchanged", cfgRdData, V_ON);
    @(negedge clk);
    check("R3", "fault one cycle", 64'(cfgFault), 64'd0);
    cfg_wr(V_ON | (64'd1 << PAW));
    check("R3", "high addr fault", 64'(cfgFault), 64'd1);
    check("R3", "high addr unchanged", cfgRdData, V_ON);
    cfg_wr(V_ON | 64'h200);
    check("R3", "bit9 fault", 64'(cfgFault), 64'd1);
    cfg_wr(V_BADMD);
    check("R4", "ext without enable", 64'(cfgFault), 64'd1);
    check("R4", "unchanged", cfgRdData, V_ON);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    cfg_wr(V_EXT);
    check("R6", "on to ext legal", 64'(cfgFault), 64'd0);
    check("R2", "ext visible", cfgRdData, V_EXT);
    check("R2", "extActive", 64'(extActive), 64'd1);
    win_rd(BASE | 36'h020, d);  check("R13", "id low byte", 64'(d), 64'h0000_005A);
    win_wr(BASE | 36'h020, 32'h7700_0000);
    check("R13", "id write fault", 64'(winFault), 64'd1);
    @(negedge clk);
    check("R13", "win fault one cycle", 64'(winFault), 64'd0);
    win_rd(BASE | 36'h020, d);  check("R13", "id unchanged", 64'(d), 64'h0000_005A);
    cfg_wr(V_ON);
    check("R5", "ext to on fault", 64'(cfgFault), 64'd1);
    check("R5", "still ext", cfgRdData, V_EXT);
    cfg_wr(V_BADMD);
    check("R4", "bad mode from ext", 64'(cfgFault), 64'd1);
    cfg_wr(V_OFF);
    check("R5", "ext to off legal", 64'(cfgFault), 64'd0);
    check("R9", "present clear", 64'(presentOut), 64'd0);
    cfg_wr(V_EXT);
    check("R6", "off to ext fault", 64'(cfgFault), 64'd1);
    check("R6", "still off", cfgRdData, V_OFF);
    win_rd(BASE | 36'h030, d);  check("R9", "version all ones", 64'(d), 64'hFFFF_FFFF);
    win_rd(BASE | 36'h080, d);  check("R9", "tpr all ones", 64'(d), 64'hFFFF_FFFF);
    win_wr(BASE | 36'h020, 32'h1100_0000);
    check("R9", "no fault on write", 64'(winFault), 64'd0);
    cfg_wr(V_ON);
    check("R2", "off to on", cfgRdData, V_ON);
    win_rd(BASE | 36'h020, d);  check("R9", "write dropped", 64'(d), 64'h5A00_0000);
  endtask

  task automatic t_relocate();
    logic [31:0] d;
    cfg_wr(64'(ALT) | 64'h900);
    check("R8", "move legal", 64'(cfgFault), 64'd0);
    win_rd(ALT | 36'h030, d);   check("R8", "version at new base", 64'(d), 64'(VER));
    win_rd(BASE | 36'h030, d);  check("R8", "old base silent", 64'(d), 64'h0);
    cfg_wr(V_ON);
    win_rd(BASE | 36'h030, d);  check("R8", "version restored", 64'(d), 64'(VER));
  endtask

  task automatic t_noext();
    @(negedge clk);
    nxWrEn = 1'b1; nxWrData = V_EXT;
    @(negedge clk);
    nxWrEn = 1'b0;
    check("R7", "ext unsupported fault", 64'(nxFault), 64'd1);
    check("R7", "unchanged", nxRdData, RST_VAL);
    @(negedge clk);
    nxWrEn = 1'b1; nxWrData = V_OFF;
    @(negedge clk);
    nxWrEn = 1'b0;
    check("R7", "disable still legal", nxRdData, V_OFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_reserved();
    t_modes();
    t_relocate();
    t_noext();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      vecCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

endmodule